// File: doc/BRIEF.md
# PCI Target Local-Side Memory Adapter

This block sits between the local side of a 64-bit PCI target core and two 32-bit synchronous RAM banks, one for the low DWORD and one for the high DWORD of each QWORD location. When a target transaction begins, it captures the starting QWORD index and the transfer direction. It then advances its own address counter on every accepted data phase, because the bus gives only the first address of a burst.

On writes it raises a separate write enable for each bank. When a 32-bit initiator addresses the high DWORD, the data arrives on the low lane, so the block routes that lane into the high bank. On reads it drives the RAM clock enable only on acknowledged phases, so the RAM output register holds its value while the initiator inserts wait states. Both 32-bit read lanes are always driven onto the 64-bit read bus. Matching the request against the base address is done elsewhere and arrives as a single hit input.

Top module: `pci_tgt_mem_adapter`

## Requirements
- R1: A synchronous active-low reset clears the address counter to zero and leaves every write enable and the RAM clock enable low while no strobe is active.
- R2: A transaction start is a clock edge at which `frame_n` is low and was high at the previous edge. That edge loads the counter with `start_addr` shifted right by 3, truncated to `MEM_AW` bits, and it is visible on `ram_addr` after that edge. The same edge captures the direction from `cmd[0]`: 1 is write, 0 is read.
- R3: In a write transaction, a phase with `dxfr_n` = 0, `bar_hit` = 1 and `hdat_ack_n` = 0 advances the counter by one at the next edge.
- R4: In a read transaction, a phase with `ack_n` = 0, `bar_hit` = 1 and `hdat_ack_n` = 0 advances the counter by one at the next edge.
- R5: The counter holds its value on a phase with `hdat_ack_n` = 1, which is a low-DWORD-only phase, and on any phase with `bar_hit` = 0. It wraps from 2^MEM_AW-1 to 0.
- R6: Bank write enables are raised only when `dxfr_n` = 0, the direction is write and `bar_hit` = 1. `ram_we_lo` additionally needs `ldat_ack_n` = 0 or `wide_xfer` = 1. `ram_we_hi` additionally needs `hdat_ack_n` = 0 or `wide_xfer` = 1. A missed BAR leaves the RAM unchanged.
- R7: `ram_d_lo` is `wr_data[31:0]`. `ram_d_hi` is `wr_data[31:0]` when `wide_xfer` = 0 and `hdat_ack_n` = 0, and `wr_data[63:32]` otherwise.
- R8: `ram_ce` is high on any write-enabled phase and on any read phase that meets the R4 conditions except `hdat_ack_n`. Otherwise it is low, so read data stays unchanged through initiator wait states.
- R9: `rd_data` is `{ram_q_hi, ram_q_lo}` at all times, with both lanes driven for every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Local frame, active low; falling edge starts a transaction |
| start_addr | input | 32 | Byte start address of the transaction |
| cmd | input | 4 | Local bus command; bit 0 gives the direction |
| bar_hit | input | 1 | Request falls in this memory's window |
| dxfr_n | input | 1 | Data-transfer strobe, active low |
| ack_n | input | 1 | Target acknowledge, active low |
| hdat_ack_n | input | 1 | High DWORD on the local side this phase, active low |
| ldat_ack_n | input | 1 | Low DWORD on the local side this phase, active low |
| wide_xfer | input | 1 | A 64-bit transfer is in progress |
| wr_data | input | 64 | Local write data |
| ram_q_lo | input | 32 | Low bank read output |
| ram_q_hi | input | 32 | High bank read output |
| ram_addr | output | MEM_AW | QWORD index to both banks |
| ram_we_lo | output | 1 | Low bank write enable |
| ram_we_hi | output | 1 | High bank write enable |
| ram_d_lo | output | 32 | Low bank write data |
| ram_d_hi | output | 32 | High bank write data |
| ram_ce | output | 1 | RAM clock enable |
| rd_data | output | 64 | Local read data |

## Verification
The bench targets 32-bit bursts that begin on the high DWORD. A design that advanced on low-only phases would write the next high half one location too far. It also runs bursts across the top of the address space, where a counter that failed to wrap would leave the first locations unwritten. Writes with the BAR missed are included: a design that ignored the hit would overwrite memory and move the counter. Read bursts have uneven wait states, which would expose a clock enable that stayed high during waits, because the read data would move on before the initiator took it.

// File: rtl/pci_tgt_mem_pkg.sv
package pci_tgt_mem_pkg;

  localparam int unsigned DWORD_W = 32;

  typedef struct packed {
    logic we_lo;
    logic we_hi;
    logic ce;
    logic inc;
  } mem_strb_t;

  // byte address to word index for a lane width of 2**offs_w bytes
  function automatic logic [31:0] word_index(input logic [31:0] byte_addr,
                                             input int unsigned offs_w);
    return byte_addr >> offs_w;
  endfunction

  // lowest command bit selects direction, 1 = write
  function automatic logic cmd_is_write(input logic [3:0] command);
    return command[0];
  endfunction

  // narrow initiator writing the upper half: data sits on the low lane
  function automatic logic hi_from_low_lane(input logic wide, input logic hdat_n);
    return !wide && !hdat_n;
  endfunction

endpackage

// File: rtl/pci_tgt_mem_addr_ctr.sv
module pci_tgt_mem_addr_ctr #(
  parameter int unsigned MEM_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MEM_AW-1:0] load_idx,
  input  logic              inc,
  output logic [MEM_AW-1:0] idx
);

  logic [MEM_AW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_idx;
    end else if (inc) begin
      idx_q <= idx_q + MEM_AW'(1);
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/pci_tgt_mem_strobe_gen.sv
module pci_tgt_mem_strobe_gen
  import pci_tgt_mem_pkg::*;
#(
  parameter bit DW64 = 1'b1
) (
  input  logic      dir_wr,
  input  logic      bar_hit,
  input  logic      dxfr_n,
  input  logic      ack_n,
  input  logic      hdat_n,
  input  logic      ldat_n,
  input  logic      wide,
  output mem_strb_t strb,
  output logic      rd_hit,
  output logic      wr_hit
);

  assign wr_hit = !dxfr_n && dir_wr && bar_hit;
  assign rd_hit = !ack_n && !dir_wr && bar_hit;

  generate
    if (DW64) begin : g_w64
      assign strb.we_lo = wr_hit && (!ldat_n || wide);
      assign strb.we_hi = wr_hit && (!hdat_n || wide);
      assign strb.inc   = (wr_hit || rd_hit) && !hdat_n;
    end else begin : g_w32
      assign strb.we_lo = wr_hit;
      assign strb.we_hi = 1'b0;
      assign strb.inc   = wr_hit || rd_hit;
    end
  endgenerate

  assign strb.ce = wr_hit || rd_hit;

endmodule

// File: rtl/pci_tgt_mem_wr_steer.sv
module pci_tgt_mem_wr_steer
  import pci_tgt_mem_pkg::*;
#(
  parameter bit DW64 = 1'b1
) (
  input  logic [2*DWORD_W-1:0] wr_data,
  input  logic                 wide,
  input  logic                 hdat_n,
  output logic [DWORD_W-1:0]   d_lo,
  output logic [DWORD_W-1:0]   d_hi
);

  assign d_lo = wr_data[DWORD_W-1:0];

  generate
    if (DW64) begin : g_w64
      always_comb begin
        if (hi_from_low_lane(wide, hdat_n)) d_hi = wr_data[DWORD_W-1:0];
        else                                d_hi = wr_data[2*DWORD_W-1:DWORD_W];
      end
    end else begin : g_w32
      assign d_hi = '0;
    end
  endgenerate

endmodule

// File: rtl/pci_tgt_mem_adapter.sv
module pci_tgt_mem_adapter
  import pci_tgt_mem_pkg::*;
#(
  parameter int unsigned MEM_AW = 4,
  parameter bit          DW64   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [31:0]       start_addr,
  input  logic [3:0]        cmd,
  input  logic              bar_hit,
  input  logic              dxfr_n,
  input  logic              ack_n,
  input  logic              hdat_ack_n,
  input  logic              ldat_ack_n,
  input  logic              wide_xfer,
  input  logic [63:0]       wr_data,
  input  logic [31:0]       ram_q_lo,
  input  logic [31:0]       ram_q_hi,
  output logic [MEM_AW-1:0] ram_addr,
  output logic              ram_we_lo,
  output logic              ram_we_hi,
  output logic [31:0]       ram_d_lo,
  output logic [31:0]       ram_d_hi,
  output logic              ram_ce,
  output logic [63:0]       rd_data
);

  localparam int unsigned OFFS_W = DW64 ? 3 : 2;

  // named events, visible to the bound checker
  logic              frame_q;
  logic              dir_q;
  logic              start_evt;
  logic              inc_evt;
  logic              rd_inc_evt;
  logic              wr_evt;
  logic [MEM_AW-1:0] ld_idx;
  mem_strb_t         strb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      dir_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      if (start_evt) dir_q <= cmd_is_write(cmd);
    end
  end

  assign start_evt = frame_q && !frame_n;
  assign ld_idx    = MEM_AW'(word_index(start_addr, OFFS_W));

  pci_tgt_mem_strobe_gen #(.DW64(DW64)) strb_i (
    .dir_wr (dir_q),
    .bar_hit(bar_hit),
    .dxfr_n (dxfr_n),
    .ack_n  (ack_n),
    .hdat_n (hdat_ack_n),
    .ldat_n (ldat_ack_n),
    .wide   (wide_xfer),
    .strb   (strb),
    .rd_hit (rd_inc_evt),
    .wr_hit (wr_evt)
  );

  assign inc_evt = strb.inc;

  pci_tgt_mem_addr_ctr #(.MEM_AW(MEM_AW)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_evt),
    .load_idx(ld_idx),
    .inc     (inc_evt),
    .idx     (ram_addr)
  );

  pci_tgt_mem_wr_steer #(.DW64(DW64)) steer_i (
    .wr_data(wr_data),
    .wide   (wide_xfer),
    .hdat_n (hdat_ack_n),
    .d_lo   (ram_d_lo),
    .d_hi   (ram_d_hi)
  );

  assign ram_we_lo = strb.we_lo;
  assign ram_we_hi = strb.we_hi;
  assign ram_ce    = strb.ce;

  generate
    if (DW64) begin : g_rd64
      assign rd_data = {ram_q_hi, ram_q_lo};
    end else begin : g_rd32
      logic unused_q_hi;
      assign unused_q_hi = ^ram_q_hi;
      assign rd_data = {32'd0, ram_q_lo};
    end
  endgenerate

endmodule

// File: rtl/pci_tgt_mem_chk.sv
module pci_tgt_mem_chk #(
  parameter int unsigned MEM_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              inc_evt,
  input logic              rd_inc_evt,
  input logic [MEM_AW-1:0] ld_idx,
  input logic [MEM_AW-1:0] ram_addr,
  input logic              ram_we_lo,
  input logic              ram_we_hi,
  input logic              ram_ce,
  input logic              dxfr_n,
  input logic              bar_hit,
  input logic              dir_wr,
  input logic              wide_xfer,
  input logic              hdat_ack_n,
  input logic [31:0]       wr_lo,
  input logic [31:0]       ram_d_lo,
  input logic [31:0]       ram_d_hi
);

  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ram_addr == $past(ld_idx));

  a_r3_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && inc_evt) |=> ram_addr == ($past(ram_addr) + MEM_AW'(1)));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !inc_evt) |=> $stable(ram_addr));

  a_r5_inc_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |-> (!hdat_ack_n && bar_hit));

  a_r6_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_lo || ram_we_hi) |-> (!dxfr_n && bar_hit && dir_wr));

  a_r7_lo_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_lo |-> ram_d_lo == wr_lo);

  a_r7_hi_steer: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_hi && !wide_xfer && !hdat_ack_n) |-> ram_d_hi == wr_lo);

  a_r8_ce_covers_we: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce |-> (!ram_we_lo && !ram_we_hi));

  a_r8_ce_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inc_evt |-> ram_ce);

endmodule

bind pci_tgt_mem_adapter pci_tgt_mem_chk #(.MEM_AW(MEM_AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .inc_evt   (inc_evt),
  .rd_inc_evt(rd_inc_evt),
  .ld_idx    (ld_idx),
  .ram_addr  (ram_addr),
  .ram_we_lo (ram_we_lo),
  .ram_we_hi (ram_we_hi),
  .ram_ce    (ram_ce),
  .dxfr_n    (dxfr_n),
  .bar_hit   (bar_hit),
  .dir_wr    (dir_q),
  .wide_xfer (wide_xfer),
  .hdat_ack_n(hdat_ack_n),
  .wr_lo     (wr_data[31:0]),
  .ram_d_lo  (ram_d_lo),
  .ram_d_hi  (ram_d_hi)
);

// File: tb/pci_tgt_mem_adapter_tb_top.sv
`timescale 1ns/1ps
module pci_tgt_mem_adapter_tb_top;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_n;
  logic [31:0]   start_addr;
  logic [3:0]    cmd;
  logic          bar_hit;
  logic          dxfr_n;
  logic          ack_n;
  logic          hdat_ack_n;
  logic          ldat_ack_n;
  logic          wide_xfer;
  logic [63:0]   wr_data;
  logic [31:0]   ram_q_lo;
  logic [31:0]   ram_q_hi;
  logic [AW-1:0] ram_addr;
  logic          ram_we_lo;
  logic          ram_we_hi;
  logic [31:0]   ram_d_lo;
  logic [31:0]   ram_d_hi;
  logic          ram_ce;
  logic [63:0]   rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] mem_lo [DEPTH];
  logic [31:0] mem_hi [DEPTH];
  logic [31:0] exp_lo [DEPTH];
  logic [31:0] exp_hi [DEPTH];

  always #4 clk = ~clk;

  pci_tgt_mem_adapter #(.MEM_AW(AW), .DW64(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .start_addr(start_addr),
    .cmd(cmd), .bar_hit(bar_hit), .dxfr_n(dxfr_n), .ack_n(ack_n),
    .hdat_ack_n(hdat_ack_n), .ldat_ack_n(ldat_ack_n), .wide_xfer(wide_xfer),
    .wr_data(wr_data), .ram_q_lo(ram_q_lo), .ram_q_hi(ram_q_hi),
    .ram_addr(ram_addr), .ram_we_lo(ram_we_lo), .ram_we_hi(ram_we_hi),
    .ram_d_lo(ram_d_lo), .ram_d_hi(ram_d_hi), .ram_ce(ram_ce), .rd_data(rd_data)
  );

  // behavioural banks with clock enable and registered output
  always_ff @(posedge clk) begin
    if (ram_ce) begin
      if (ram_we_lo) mem_lo[ram_addr] <= ram_d_lo;
      if (ram_we_hi) mem_hi[ram_addr] <= ram_d_hi;
      ram_q_lo <= mem_lo[ram_addr];
      ram_q_hi <= mem_hi[ram_addr];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int seed, input int i);
    return {32'hC000_0000 + 32'(seed * 256 + i), 32'h1000_0000 + 32'(seed * 4096 + i * 3)};
  endfunction

  task automatic idle_strobes();
    dxfr_n = 1'b1; ack_n = 1'b1; hdat_ack_n = 1'b1; ldat_ack_n = 1'b1;
    wide_xfer = 1'b0; bar_hit = 1'b1;
  endtask

  task automatic begin_txn(input int a, input bit wr);
    @(negedge clk);
    frame_n = 1'b1;
    @(negedge clk);
    frame_n    = 1'b0;
    start_addr = 32'h4000_0000 | 32'(a << 3);
    cmd        = wr ? 4'h7 : 4'h6;
  endtask

  task automatic cmp_mem(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      chk(tag, {32'd0, mem_lo[i]}, {32'd0, exp_lo[i]});
      chk(tag, {32'd0, mem_hi[i]}, {32'd0, exp_hi[i]});
    end
  endtask

  // 64-bit burst; hit=0 exercises the missed BAR
  task automatic wr64(input int a, input int n, input int seed, input bit hit);
    int cur = a % DEPTH;
    begin_txn(a, 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(i == 0 ? "R2 load" : (hit ? "R3 advance" : "R5 miss hold"), 64'(ram_addr), 64'(cur));
      wr_data = pattern(seed, i);
      dxfr_n = 1'b0; hdat_ack_n = 1'b0; ldat_ack_n = 1'b0; wide_xfer = 1'b1; bar_hit = hit;
      if (hit) begin
        exp_lo[cur] = wr_data[31:0];
        exp_hi[cur] = wr_data[63:32];
        cur = (cur + 1) % DEPTH;
      end
    end
    @(negedge clk);
    chk(hit ? "R3 final" : "R5 miss final", 64'(ram_addr), 64'(cur));
    idle_strobes();
    frame_n = 1'b1;
  endtask

  // 32-bit burst, lanes alternate, starting on the high lane when first_hi
  task automatic wr32(input int a, input int n, input int seed, input bit first_hi);
    int cur = a % DEPTH;
    bit lane_hi = first_hi;
    begin_txn(a, 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(i == 0 ? "R2 load" : "R5 lane advance", 64'(ram_addr), 64'(cur));
      wr_data = pattern(seed, i);
      dxfr_n = 1'b0; wide_xfer = 1'b0; bar_hit = 1'b1;
      hdat_ack_n = !lane_hi; ldat_ack_n = lane_hi;
      #1;
      if (lane_hi) chk("R7 hi from low lane", 64'(ram_d_hi), 64'(wr_data[31:0]));
      else         chk("R6 low only", {62'd0, ram_we_lo, ram_we_hi}, 64'd2);
      if (lane_hi) begin
        exp_hi[cur] = wr_data[31:0];
        cur = (cur + 1) % DEPTH;
      end else begin
        exp_lo[cur] = wr_data[31:0];
      end
      lane_hi = !lane_hi;
    end
    @(negedge clk);
    chk("R5 lane final", 64'(ram_addr), 64'(cur));
    idle_strobes();
    frame_n = 1'b1;
  endtask

  task automatic rd_burst(input int a, input int n);
    int cur = a % DEPTH;
    logic [63:0] held;
    begin_txn(a, 1'b0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) chk("R2 read load", 64'(ram_addr), 64'(cur));
      ack_n = 1'b0; hdat_ack_n = 1'b0; ldat_ack_n = 1'b0; bar_hit = 1'b1;
      @(negedge clk);
      ack_n = 1'b1; hdat_ack_n = 1'b1; ldat_ack_n = 1'b1;
      chk("R9 both lanes", rd_data, {exp_hi[cur], exp_lo[cur]});
      chk("R9 lane order", rd_data, {ram_q_hi, ram_q_lo});
      cur = (cur + 1) % DEPTH;
      chk("R4 read advance", 64'(ram_addr), 64'(cur));
      held = rd_data;
      for (int w = 0; w < k % 3; w++) begin
        @(negedge clk);
        chk("R8 wait hold", rd_data, held);
        chk("R8 ce low", 64'(ram_ce), 64'd0);
      end
    end
    @(negedge clk);
    idle_strobes();
    frame_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_lo[i] = '0; mem_hi[i] = '0; exp_lo[i] = '0; exp_hi[i] = '0;
    end
    ram_q_lo = '0; ram_q_hi = '0;
    rst_n = 1'b0; frame_n = 1'b1; start_addr = '0; cmd = '0; wr_data = '0;
    idle_strobes();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset index", 64'(ram_addr), 64'd0);
    chk("R1 reset strobes", {61'd0, ram_we_lo, ram_we_hi, ram_ce}, 64'd0);

    wr64(2, 5, 1, 1'b1);
    cmp_mem("R6 wide write");
    wr64(14, 4, 2, 1'b1);
    cmp_mem("R5 wrap write");
    wr32(5, 6, 3, 1'b0);
    cmp_mem("R7 narrow low first");
    wr32(9, 4, 4, 1'b1);
    cmp_mem("R7 narrow high first");
    wr64(3, 3, 5, 1'b0);
    cmp_mem("R6 bar miss");
    rd_burst(2, 5);
    rd_burst(15, 3);
    rd_burst(5, 6);
    cmp_mem("R6 final");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule